// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block repeats a status-read command against a serial flash until the returned status word satisfies a programmed condition. It does not drive the serial pins itself. It talks to a command sequencer through a three-signal handshake. The engine pulses `seq_start` for one cycle. The sequencer later pulses `seq_done` for one cycle and presents the status word on `seq_rdata` in that same cycle.

Each returned word is trimmed to its programmed byte count and then compared against a match value under a mask, in either an all-bits or an any-bit sense. Between one read and the next, the engine waits for a programmable number of idle cycles. It can end polling on the first hit, or it can keep polling until it is aborted or disabled. A sticky flag records that a hit was seen. The most recent trimmed status word stays visible at the ports.

Top module: `flash_stat_poller`

## Requirements
- R1: After reset, `busy`, `match_flag` and `seq_start` are 0 and `last_status` is all zeros.
- R2: A `start` pulse seen while `enable` is 1 and the engine is idle makes `busy` 1 in the next cycle, with `seq_start` high for exactly that one cycle. A `start` while `enable` is 0 is ignored.
- R3: `cfg_size` holds the byte count minus one (0 = 1 byte … 3 = 4 bytes). Only that many least significant bytes of a read take part in the comparison. `last_status` takes the read word with all bytes above that count forced to zero.
- R4: With `cfg_or_mode` = 0, a read hits when every bit whose `cfg_mask` bit is 1 equals the matching `cfg_match` bit. An all-zero mask always hits.
- R5: With `cfg_or_mode` = 1, a read hits when at least one bit whose `cfg_mask` bit is 1 equals the matching `cfg_match` bit. An all-zero mask never hits.
- R6: When polling continues, the next `seq_start` comes exactly `cfg_gap`+1 cycles after the cycle in which `seq_done` was taken, for any `cfg_gap` from 0 to 65535.
- R7: With `cfg_auto_stop` = 1, the first hit ends polling. `busy` is 0 in the cycle after the hitting `seq_done`, and no further `seq_start` follows.
- R8: With `cfg_auto_stop` = 0, each hit sets `match_flag` and polling goes on.
- R9: `match_flag` stays 1 until a cycle with `match_clr` = 1. A hit in that same cycle wins over the clear.
- R10: An `abort` pulse, or `enable` at 0, ends polling. During the gap the engine is idle in the next cycle. During a read it waits for that read's `seq_done` and then goes idle without issuing another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; low stops polling |
| start | input | 1 | One-cycle request to begin polling |
| abort | input | 1 | One-cycle request to end polling |
| cfg_match | input | 32 | Value compared against the status word |
| cfg_mask | input | 32 | Selects the bits that take part in the compare |
| cfg_size | input | 2 | Status bytes minus one |
| cfg_or_mode | input | 1 | 0 = all selected bits equal, 1 = any selected bit equal |
| cfg_auto_stop | input | 1 | End polling on the first hit |
| cfg_gap | input | 16 | Idle cycles between reads |
| match_clr | input | 1 | Write-one clear of `match_flag` |
| seq_start | output | 1 | One-cycle request to the sequencer to read status |
| seq_done | input | 1 | Sequencer read finished, data valid |
| seq_rdata | input | 32 | Status word from the sequencer |
| match_flag | output | 1 | Sticky hit indicator |
| busy | output | 1 | Polling in progress |
| last_status | output | 32 | Last status word, trimmed to the byte count |

## Verification
A wrong control state shows up at the ports within one read. A stuck or skipped gap count moves the next `seq_start` away from its exact cycle. A missed stop either lets another `seq_start` through or keeps `busy` high past the hitting read. A wrong byte trim or compare sense changes which read ends an auto-stopped poll, so the count of reads and the value held in `last_status` both differ from the value predicted from the stimulus as soon as that poll ends.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ISSUE = 2'd1,
    PS_WAIT  = 2'd2,
    PS_GAP   = 2'd3
  } poll_state_e;
endpackage

// File: rtl/poll_cmp.sv
module poll_cmp #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] match_val,
  input  logic [DATA_W-1:0] mask,
  input  logic [SIZE_W-1:0] size_m1,
  input  logic              or_mode,
  output logic              hit,
  output logic [DATA_W-1:0] kept
);
  localparam int NBYTES = DATA_W / 8;

  // Byte lanes up to and including size_m1 are kept.
  function automatic logic [DATA_W-1:0] lane_keep(input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] k;
    k = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (b <= int'(sz)) k[b*8 +: 8] = 8'hFF;
    end
    return k;
  endfunction

  function automatic logic all_equal(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] m,
                                     input logic [DATA_W-1:0] k);
    return ((d ^ m) & k) == '0;
  endfunction

  function automatic logic any_equal(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] m,
                                     input logic [DATA_W-1:0] k);
    return |(~(d ^ m) & k);
  endfunction

  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] eff_mask;

  always_comb begin
    keep     = lane_keep(size_m1);
    eff_mask = mask & keep;
    kept     = rdata & keep;
    hit      = or_mode ? any_equal(rdata, match_val, eff_mask)
                       : all_equal(rdata, match_val, eff_mask);
  end
endmodule

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic abort,
  input  logic cmp_hit,
  input  logic auto_stop,
  input  logic gap_none,
  input  logic timer_zero,
  input  logic seq_done,
  output logic seq_start,
  output logic busy,
  output logic read_end,
  output logic gap_load,
  output logic gap_dec
);
  poll_state_e st, nxt;
  logic        pend;
  logic        stop_req;

  assign stop_req = abort || !enable;

  always_comb begin
    nxt      = st;
    gap_load = 1'b0;
    gap_dec  = 1'b0;
    case (st)
      PS_IDLE:  if (start && enable && !abort) nxt = PS_ISSUE;
      PS_ISSUE: nxt = PS_WAIT;
      PS_WAIT: begin
        if (seq_done) begin
          if ((cmp_hit && auto_stop) || pend || stop_req) nxt = PS_IDLE;
          else if (gap_none) nxt = PS_ISSUE;
          else begin
            nxt      = PS_GAP;
            gap_load = 1'b1;
          end
        end
      end
      PS_GAP: begin
        if (stop_req)        nxt = PS_IDLE;
        else if (timer_zero) nxt = PS_ISSUE;
        else                 gap_dec = 1'b1;
      end
      default: nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PS_IDLE;
      pend <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt == PS_IDLE) pend <= 1'b0;
      else if ((st == PS_ISSUE || st == PS_WAIT) && stop_req) pend <= 1'b1;
    end
  end

  assign seq_start = (st == PS_ISSUE);
  assign busy      = (st != PS_IDLE);
  assign read_end  = (st == PS_WAIT) && seq_done;

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start) && $past(enable));
  // R10
  abort_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end && pend) |=> !busy);
endmodule

// File: rtl/flash_stat_poller.sv
module flash_stat_poller #(
  parameter int DATA_W = 32,
  parameter int GAP_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enable,
  input  logic                              start,
  input  logic                              abort,
  input  logic [DATA_W-1:0]                 cfg_match,
  input  logic [DATA_W-1:0]                 cfg_mask,
  input  logic [$clog2(DATA_W/8)-1:0]       cfg_size,
  input  logic                              cfg_or_mode,
  input  logic                              cfg_auto_stop,
  input  logic [GAP_W-1:0]                  cfg_gap,
  input  logic                              match_clr,
  output logic                              seq_start,
  input  logic                              seq_done,
  input  logic [DATA_W-1:0]                 seq_rdata,
  output logic                              match_flag,
  output logic                              busy,
  output logic [DATA_W-1:0]                 last_status
);
  localparam int SIZE_W = $clog2(DATA_W/8);

  logic              cmp_hit;
  logic [DATA_W-1:0] cmp_kept;
  logic              read_end;
  logic              match_hit;
  logic              gap_load;
  logic              gap_dec;
  logic              timer_zero;
  logic [GAP_W-1:0]  gap_reload;

  assign gap_reload = cfg_gap - {{(GAP_W-1){1'b0}}, 1'b1};

  poll_cmp #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_cmp (
    .rdata     (seq_rdata),
    .match_val (cfg_match),
    .mask      (cfg_mask),
    .size_m1   (cfg_size),
    .or_mode   (cfg_or_mode),
    .hit       (cmp_hit),
    .kept      (cmp_kept)
  );

  poll_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_reload),
    .dec      (gap_dec),
    .zero     (timer_zero)
  );

  poll_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start      (start),
    .abort      (abort),
    .cmp_hit    (cmp_hit),
    .auto_stop  (cfg_auto_stop),
    .gap_none   (cfg_gap == '0),
    .timer_zero (timer_zero),
    .seq_done   (seq_done),
    .seq_start  (seq_start),
    .busy       (busy),
    .read_end   (read_end),
    .gap_load   (gap_load),
    .gap_dec    (gap_dec)
  );

  assign match_hit = read_end && cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_status <= '0;
      match_flag  <= 1'b0;
    end else begin
      if (read_end)       last_status <= cmp_kept;
      if (match_hit)      match_flag  <= 1'b1;
      else if (match_clr) match_flag  <= 1'b0;
    end
  end

  // R7
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && cfg_auto_stop) |=> (!busy && !seq_start));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> match_flag);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);
  // R5
  or_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end && cfg_or_mode && cfg_mask == '0) |-> !match_hit);
endmodule

// File: tb/flash_stat_poller_test.sv
`timescale 1ns/100ps
module flash_stat_poller_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1, start = 1'b0, abort = 1'b0, match_clr = 1'b0;
  logic [31:0] cfg_match = '0, cfg_mask = '0;
  logic [1:0]  cfg_size = 2'd3;
  logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1;
  logic [15:0] cfg_gap = '0;
  logic        seq_start, seq_done = 1'b0;
  logic [31:0] seq_rdata = '0;
  logic        match_flag, busy;
  logic [31:0] last_status;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_starts = 0, n_done = 0, last_done = 0;
  int lat_fix = 0;
  logic [31:0] resp_mem [0:15];

  flash_stat_poller uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .abort(abort),
    .cfg_match(cfg_match), .cfg_mask(cfg_mask), .cfg_size(cfg_size),
    .cfg_or_mode(cfg_or_mode), .cfg_auto_stop(cfg_auto_stop), .cfg_gap(cfg_gap),
    .match_clr(match_clr), .seq_start(seq_start), .seq_done(seq_done),
    .seq_rdata(seq_rdata), .match_flag(match_flag), .busy(busy),
    .last_status(last_status)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_of(input int nb);
    logic [31:0] k = '0;
    for (int i = 0; i < nb * 8; i++) k[i] = 1'b1;
    return k;
  endfunction

  // Counts selected bits and equal selected bits.
  function automatic bit ref_hit(input logic [31:0] d, input logic [31:0] m,
                                 input logic [31:0] k, input int nb, input bit orm);
    int tot = 0, eq = 0;
    for (int i = 0; i < nb * 8; i++) begin
      if (k[i]) begin
        tot++;
        if (d[i] == m[i]) eq++;
      end
    end
    return orm ? (eq > 0) : (eq == tot);
  endfunction

  // Sequencer model; also checks the gap (R6).
  initial begin
    forever begin
      @(negedge clk);
      seq_done = 1'b0;
      if (seq_start) begin
        n_starts++;
        if (n_starts > 1)
          expect_eq("R6 gap", cyc - last_done, int'(cfg_gap) + 1);
        begin
          int lat = (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 3);
          repeat (lat) @(negedge clk);
        end
        seq_done  = 1'b1;
        seq_rdata = resp_mem[n_done % 16];
        n_done++;
        last_done = cyc;
      end
    end
  end

  task automatic clear_counts();
    n_starts = 0;
    n_done = 0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_eq("R2 busy after start", busy, 1);
    expect_eq("R2 seq_start pulse", seq_start, 1);
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic wait_starts(input int n);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (n_starts >= n) break;
    end
  endtask

  task automatic pulse_abort();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    match_clr = 1'b1;
    @(negedge clk);
    match_clr = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) resp_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_eq("R1 busy", busy, 0);
    expect_eq("R1 flag", match_flag, 0);
    expect_eq("R1 seq_start", seq_start, 0);
    expect_eq("R1 last_status", last_status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start while disabled is ignored
    enable = 1'b0;
    clear_counts();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    expect_eq("R2 disabled busy", busy, 0);
    expect_eq("R2 disabled reads", n_starts, 0);
    enable = 1'b1;

    // R6 gap 7 and gap 0, AND mode, stop on third read (R7)
    for (int g = 0; g < 2; g++) begin
      cfg_gap = (g == 0) ? 16'd7 : 16'd0;
      cfg_size = 2'd3; cfg_or_mode = 0; cfg_auto_stop = 1;
      cfg_mask = 32'hFF; cfg_match = 32'h55;
      resp_mem[0] = 32'h0; resp_mem[1] = 32'h1; resp_mem[2] = 32'hAB55;
      clear_counts();
      do_start();
      wait_idle(500);
      repeat (3) @(negedge clk);
      expect_eq("R7 reads to first hit", n_starts, 3);
      expect_eq("R7 busy low", busy, 0);
      expect_eq("R4 flag", match_flag, 1);
      pulse_clr();
      expect_eq("R9 clear", match_flag, 0);
    end

    // R3 one byte compared, upper bytes trimmed
    cfg_gap = 16'd1; cfg_size = 2'd0; cfg_mask = 32'hFFFF_FFFF; cfg_match = 32'hAA;
    resp_mem[0] = 32'h1234_56AA;
    clear_counts();
    do_start();
    wait_idle(200);
    expect_eq("R3 one byte reads", n_starts, 1);
    expect_eq("R3 trimmed status", last_status, 32'hAA);
    pulse_clr();
    // R3 four bytes: same word now fails
    cfg_size = 2'd3;
    resp_mem[0] = 32'h1234_56AA; resp_mem[1] = 32'h0000_00AA;
    clear_counts();
    do_start();
    wait_idle(200);
    expect_eq("R3 four byte reads", n_starts, 2);
    expect_eq("R3 full status", last_status, 32'hAA);
    pulse_clr();

    // R4 zero mask in AND mode hits at once
    cfg_mask = 32'h0; cfg_or_mode = 0; resp_mem[0] = 32'hDEAD_BEEF;
    clear_counts();
    do_start();
    wait_idle(200);
    expect_eq("R4 zero mask reads", n_starts, 1);
    expect_eq("R4 zero mask flag", match_flag, 1);
    pulse_clr();

    // R5 zero mask in OR mode never hits
    cfg_or_mode = 1; cfg_gap = 16'd2;
    for (int i = 0; i < 16; i++) resp_mem[i] = 32'h5A5A_0000 + i;
    clear_counts();
    do_start();
    wait_starts(4);
    expect_eq("R5 zero mask still busy", busy, 1);
    pulse_abort();
    wait_idle(200);
    expect_eq("R5 zero mask no flag", match_flag, 0);

    // R5 OR mode partial
    cfg_mask = 32'h0F; cfg_match = 32'h0A; cfg_gap = 16'd0;
    resp_mem[0] = 32'h05; resp_mem[1] = 32'h0B;
    clear_counts();
    do_start();
    wait_idle(200);
    expect_eq("R5 or reads", n_starts, 2);
    expect_eq("R5 or flag", match_flag, 1);
    pulse_clr();

    // R8 no auto stop, then R9 sticky after abort
    cfg_auto_stop = 0; cfg_or_mode = 0; cfg_mask = 32'h0; cfg_gap = 16'd2;
    clear_counts();
    do_start();
    wait_starts(4);
    expect_eq("R8 still busy", busy, 1);
    expect_eq("R8 flag", match_flag, 1);
    pulse_abort();
    wait_idle(200);
    repeat (2) @(negedge clk);
    expect_eq("R9 sticky", match_flag, 1);
    pulse_clr();
    expect_eq("R9 cleared", match_flag, 0);

    // R10 abort during a read waits for it
    cfg_auto_stop = 1; cfg_or_mode = 1; cfg_mask = 32'h0; cfg_gap = 16'd0;
    lat_fix = 3;
    clear_counts();
    do_start();
    pulse_abort();
    expect_eq("R10 busy during read", busy, 1);
    wait_idle(50);
    repeat (3) @(negedge clk);
    expect_eq("R10 one read only", n_starts, 1);
    expect_eq("R10 idle", busy, 0);
    lat_fix = 1;

    // R10 abort during gap
    cfg_gap = 16'd30;
    clear_counts();
    do_start();
    repeat (5) @(negedge clk);
    pulse_abort();
    expect_eq("R10 abort in gap", busy, 0);
    expect_eq("R10 abort in gap reads", n_starts, 1);

    // R10 disable during gap
    clear_counts();
    do_start();
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    expect_eq("R10 disable in gap", busy, 0);
    enable = 1'b1;
    lat_fix = 0;

    // Random configurations, auto stop on
    for (int it = 0; it < 30; it++) begin
      int nb, k;
      logic [31:0] keep;
      cfg_size = 2'($urandom % 4);
      nb = int'(cfg_size) + 1;
      keep = keep_of(nb);
      cfg_or_mode = 1'($urandom % 2);
      cfg_auto_stop = 1;
      cfg_gap = 16'($urandom % 6);
      cfg_match = $urandom;
      cfg_mask = ($urandom % 5 == 0) ? 32'h0 : $urandom;
      if (cfg_or_mode && (cfg_mask & keep) == 0) cfg_mask = cfg_mask | 32'h1;
      for (int j = 0; j < 7; j++) begin
        resp_mem[j] = $urandom;
        if ($urandom % 4 == 0) resp_mem[j] = cfg_match ^ (32'h1 << ($urandom % 32));
      end
      resp_mem[7] = cfg_match ^ ($urandom & ~keep);
      k = 7;
      for (int j = 7; j >= 0; j--)
        if (ref_hit(resp_mem[j], cfg_match, cfg_mask, nb, cfg_or_mode)) k = j;
      clear_counts();
      do_start();
      wait_idle(1000);
      repeat (2) @(negedge clk);
      expect_eq("R7 random reads", n_starts, k + 1);
      expect_eq("R3 random status", last_status, resp_mem[k] & keep);
      expect_eq(cfg_or_mode ? "R5 random flag" : "R4 random flag", match_flag, 1);
      pulse_clr();
      expect_eq("R9 random clear", match_flag, 0);
    end

    summary();
    $finish;
  end
endmodule